// File: doc/BRIEF.md
# Double-Buffered Colour Palette

This block turns a stream of 8-bit pixel indices into 24-bit RGB colours through a 256-entry palette. It holds two full copies of the palette, called banks. The display path always reads the shown bank. The host writes into the other, hidden bank. The host can therefore rebuild a whole palette without tearing the picture on screen.

The host works through a small register port. Entries are written and read back by index. Each entry is packed with red in bits 23:16, green in bits 15:8 and blue in bits 7:0. A one-bit swap request is written through the control port. A status bit reports which bank is shown. The banks trade places only on a vertical-blank pulse, and only when the request differs from the status. When the two bits read equal again, the swap has finished and the next reload may begin.

The pixel path is a valid/ready stream with one register stage. An index is accepted when `pix_valid` and `pix_ready` are both high. The colour appears on `rgb_data` with `rgb_valid` on the next clock. While `rgb_valid` is high and `rgb_ready` is low, the output is held. In that state `pix_ready` stays low, so no index is lost.

Top module: `palette_dbuf`

## Requirements
- R1: After reset the control read-back is 2'b00, `rgb_valid` is 0, and every entry of both banks reads as 24'h000000.
- R2: A host write with `host_wr_en` high stores `host_wdata` at `host_idx` in the hidden bank only. Colours on the pixel path are unchanged by it.
- R3: `host_rdata` shows, in the same cycle, the hidden-bank entry at `host_idx`.
- R4: A control write with `ctrl_wr_en` high sets the request bit to `ctrl_wdata`. `ctrl_rdata` is {status, request}: bit 1 is the status and bit 0 is the request.
- R5: On a clock where `vblank_start` is high and the request differs from the status, the status takes the request value from the next cycle on. This swaps the shown and hidden banks.
- R6: The status never changes on a clock without `vblank_start`, nor when the request equals the status.
- R7: An index accepted on one clock gives, on the next clock, `rgb_valid`=1 and `rgb_data` equal to the shown-bank entry, in 8-8-8 packing.
- R8: While `rgb_valid` is 1 and `rgb_ready` is 0, `pix_ready` is 0 and `rgb_data` holds its value.
- R9: When the output is taken (`rgb_ready` high) and no new index is accepted, `rgb_valid` is 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Write the hidden-bank entry |
| host_idx | input | 8 | Entry index for host write and read |
| host_wdata | input | 24 | Entry to write, as R[23:16] G[15:8] B[7:0] |
| host_rdata | output | 24 | Hidden-bank entry at `host_idx` |
| ctrl_wr_en | input | 1 | Write the swap request bit |
| ctrl_wdata | input | 1 | New request value |
| ctrl_rdata | output | 2 | {status, request} |
| vblank_start | input | 1 | One-clock pulse at the start of vertical blank |
| pix_valid | input | 1 | Index stream valid |
| pix_ready | output | 1 | Index stream ready |
| pix_idx | input | 8 | Pixel index |
| rgb_valid | output | 1 | Colour stream valid |
| rgb_ready | input | 1 | Colour stream ready |
| rgb_data | output | 24 | Looked-up colour |

## Verification
Host read-back is combinational, so it is checked in the same cycle the index is driven. Request and status sit in registers: a control write or a vertical-blank pulse shows on `ctrl_rdata` one edge later. A looked-up colour shows on `rgb_data` one edge after the index is accepted. The bench drives inputs on the falling edge and samples on the next falling edge, which falls after exactly one rising edge. Under back-pressure the bench samples across several stalled edges before releasing the output.

// File: rtl/palette_pkg.sv
package palette_pkg;
  localparam int unsigned COMP_W = 8;
  localparam int unsigned RGB_W  = 3 * COMP_W;

  typedef struct packed {
    logic [COMP_W-1:0] red;
    logic [COMP_W-1:0] green;
    logic [COMP_W-1:0] blue;
  } rgb_t;
endpackage

// File: rtl/palette_swap_ctrl.sv
module palette_swap_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_wr,
  input  logic req_val,
  input  logic frame_edge,
  output logic req_q,
  output logic shown_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      shown_q <= 1'b0;
    end else begin
      if (req_wr) req_q <= req_val;
      // the swap uses the request held before this edge
      if (frame_edge && (req_q != shown_q)) shown_q <= req_q;
    end
  end
endmodule

// File: rtl/palette_bank.sv
module palette_bank #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [IDX_W-1:0]  raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/palette_pix_stage.sv
module palette_pix_stage #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/palette_dbuf.sv
module palette_dbuf
  import palette_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr_en,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [RGB_W-1:0] host_wdata,
  output logic [RGB_W-1:0] host_rdata,
  input  logic             ctrl_wr_en,
  input  logic             ctrl_wdata,
  output logic [1:0]       ctrl_rdata,
  input  logic             vblank_start,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [IDX_W-1:0] pix_idx,
  output logic             rgb_valid,
  input  logic             rgb_ready,
  output logic [RGB_W-1:0] rgb_data
);
  localparam int unsigned NBANK = 2;

  logic req_q, shown_q;
  logic [RGB_W-1:0] host_rd [NBANK];
  logic [RGB_W-1:0] pix_rd  [NBANK];
  rgb_t lookup;

  palette_swap_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_wr(ctrl_wr_en), .req_val(ctrl_wdata),
    .frame_edge(vblank_start),
    .req_q(req_q), .shown_q(shown_q)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    palette_bank #(.IDX_W(IDX_W), .DATA_W(RGB_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .we(host_wr_en && (shown_q != b[0])),
      .waddr(host_idx), .wdata(host_wdata),
      .raddr_a(host_idx), .rdata_a(host_rd[b]),
      .raddr_b(pix_idx),  .rdata_b(pix_rd[b])
    );
  end

  assign host_rdata = host_rd[!shown_q];
  assign lookup     = rgb_t'(pix_rd[shown_q]);
  assign ctrl_rdata = {shown_q, req_q};

  palette_pix_stage #(.DATA_W(RGB_W)) u_pix (
    .clk(clk), .rst_n(rst_n),
    .in_valid(pix_valid), .in_ready(pix_ready), .in_data(lookup),
    .out_valid(rgb_valid), .out_ready(rgb_ready), .out_data(rgb_data)
  );
endmodule

// File: rtl/palette_dbuf_chk.sv
module palette_dbuf_chk #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned RGB_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_wr_en,
  input logic             ctrl_wdata,
  input logic [1:0]       ctrl_rdata,
  input logic             vblank_start,
  input logic             pix_valid,
  input logic             pix_ready,
  input logic [IDX_W-1:0] pix_idx,
  input logic             rgb_valid,
  input logic             rgb_ready,
  input logic [RGB_W-1:0] rgb_data
);
  p_req_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_en |=> ctrl_rdata[0] == $past(ctrl_wdata));

  p_swap_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_start && (ctrl_rdata[0] != ctrl_rdata[1])) |=> ctrl_rdata[1] == $past(ctrl_rdata[0]));

  p_swap_only_at_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !vblank_start |=> $stable(ctrl_rdata[1]));

  p_accept_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready) |=> rgb_valid);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rgb_valid && !rgb_ready) |=> rgb_valid && $stable(rgb_data));

  p_stall_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rgb_valid && !rgb_ready) |-> !pix_ready);

  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rgb_ready && !pix_valid) |=> !rgb_valid);

  logic unused_idx;
  assign unused_idx = ^pix_idx;
endmodule

bind palette_dbuf palette_dbuf_chk #(.IDX_W(IDX_W), .RGB_W(palette_pkg::RGB_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ctrl_wr_en(ctrl_wr_en), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
  .vblank_start(vblank_start),
  .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_idx(pix_idx),
  .rgb_valid(rgb_valid), .rgb_ready(rgb_ready), .rgb_data(rgb_data)
);

// File: tb/tb_palette_dbuf.sv
module tb_palette_dbuf;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr_en;
  logic [7:0]  host_idx;
  logic [23:0] host_wdata;
  logic [23:0] host_rdata;
  logic        ctrl_wr_en;
  logic        ctrl_wdata;
  logic [1:0]  ctrl_rdata;
  logic        vblank_start;
  logic        pix_valid;
  logic        pix_ready;
  logic [7:0]  pix_idx;
  logic        rgb_valid;
  logic        rgb_ready;
  logic [23:0] rgb_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  palette_dbuf dut (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_idx(host_idx), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ctrl_wr_en(ctrl_wr_en), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .vblank_start(vblank_start),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_idx(pix_idx),
    .rgb_valid(rgb_valid), .rgb_ready(rgb_ready), .rgb_data(rgb_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] idx, input logic [23:0] val);
    @(negedge clk);
    host_wr_en = 1'b1; host_idx = idx; host_wdata = val;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic host_read_check(input string req, input logic [7:0] idx, input logic [23:0] exp);
    @(negedge clk);
    host_idx = idx;
    #1;
    check(req, {8'h0, host_rdata}, {8'h0, exp});
  endtask

  task automatic pixel_check(input string req, input logic [7:0] idx, input logic [23:0] exp);
    @(negedge clk);
    pix_valid = 1'b1; pix_idx = idx;
    @(negedge clk);
    pix_valid = 1'b0;
    check({req, " valid"}, {31'h0, rgb_valid}, 32'h1);
    check({req, " data"}, {8'h0, rgb_data}, {8'h0, exp});
  endtask

  task automatic set_request(input logic v);
    @(negedge clk);
    ctrl_wr_en = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_wr_en = 1'b0;
  endtask

  task automatic pulse_vblank;
    @(negedge clk);
    vblank_start = 1'b1;
    @(negedge clk);
    vblank_start = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 ctrl", {30'h0, ctrl_rdata}, 32'h0);
    check("R1 rgb_valid", {31'h0, rgb_valid}, 32'h0);
    host_read_check("R1 hidden entry", 8'h05, 24'h0);
    pixel_check("R1 shown entry", 8'h05, 24'h0);
    pixel_check("R1 shown entry top", 8'hFF, 24'h0);
  endtask

  task automatic t_load_hidden;
    host_write(8'h05, 24'h123456);
    host_write(8'hFF, 24'hA0B0C0);
    host_write(8'h00, 24'h010203);
    host_read_check("R3 readback 05", 8'h05, 24'h123456);
    host_read_check("R3 readback FF", 8'hFF, 24'hA0B0C0);
    pixel_check("R2 shown unchanged", 8'h05, 24'h0);
  endtask

  task automatic t_request_without_blank;
    set_request(1'b1);
    check("R4 request set", {30'h0, ctrl_rdata}, 32'h1);
    repeat (3) @(negedge clk);
    check("R6 no swap without blank", {30'h0, ctrl_rdata}, 32'h1);
    pixel_check("R6 still old bank", 8'h05, 24'h0);
  endtask

  task automatic t_swap;
    pulse_vblank();
    check("R5 status follows", {30'h0, ctrl_rdata}, 32'h3);
    pixel_check("R7 lookup 05", 8'h05, 24'h123456);
    pixel_check("R7 lookup FF", 8'hFF, 24'hA0B0C0);
    pixel_check("R7 lookup 00", 8'h00, 24'h010203);
    host_read_check("R3 hidden now other bank", 8'h05, 24'h0);
    pulse_vblank();
    check("R6 no swap when equal", {30'h0, ctrl_rdata}, 32'h3);
  endtask

  task automatic t_swap_back;
    host_write(8'h05, 24'h777777);
    pixel_check("R2 write hidden only", 8'h05, 24'h123456);
    set_request(1'b0);
    check("R4 request cleared", {30'h0, ctrl_rdata}, 32'h2);
    pulse_vblank();
    check("R5 swap back", {30'h0, ctrl_rdata}, 32'h0);
    pixel_check("R7 lookup after swap back", 8'h05, 24'h777777);
    host_read_check("R3 hidden keeps old", 8'h05, 24'h123456);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rgb_ready = 1'b0; pix_valid = 1'b1; pix_idx = 8'h05;
    @(negedge clk);
    pix_idx = 8'h00;
    check("R8 ready low when stalled", {31'h0, pix_ready}, 32'h0);
    repeat (2) @(negedge clk);
    check("R8 held valid", {31'h0, rgb_valid}, 32'h1);
    check("R8 held data", {8'h0, rgb_data}, {8'h0, 24'h777777});
    rgb_ready = 1'b1;
    @(negedge clk);
    pix_valid = 1'b0;
    check("R8 next after release", {8'h0, rgb_data}, {8'h0, 24'h0});
    @(negedge clk);
    check("R9 drained", {31'h0, rgb_valid}, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_wr_en = 1'b0; host_idx = '0; host_wdata = '0;
    ctrl_wr_en = 1'b0; ctrl_wdata = 1'b0; vblank_start = 1'b0;
    pix_valid = 1'b0; pix_idx = '0; rgb_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_hidden();
    t_request_without_blank();
    t_swap();
    t_swap_back();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule